// File: doc/BRIEF.md
# Stack-Operand Byte ALU

This block is the execution unit of a byte-wide stack processor. Each request carries an opcode and the two topmost stack bytes: `tos` is the top and `nos` the level below it. One clock edge later the block returns a registered result: how many bytes the stack controller must remove, how many it must then add (zero, one or two), the bytes to add, and the new value of the carry flag that conditional branches test.

Two-operand operations take `nos` as the left operand A and `tos` as the right operand B, so subtraction gives A minus B. Multiplication returns the full 16-bit product as two pushes. The low byte is pushed first and the high byte second, so the high byte becomes the new top. The stack storage and instruction sequencing sit outside this block. The multiplier can be built either from the language operator or from an explicit array of shifted partial products. A parameter selects which one.

Top module: `stk_alu`

## Requirements
- R1: After reset `done`, `pop_cnt`, `push_cnt`, `push_d0`, `push_d1` and `carry` all read zero.
- R2: `done` is high in exactly the cycle after each cycle in which `op_valid` is high. In any cycle where `done` is low, `pop_cnt` and `push_cnt` read zero.
- R3: Opcode 0 (add) gives pop 2, push 1 and `push_d0` = (nos + tos) mod 256. Carry is set to 1 exactly when the unsigned sum exceeds 255.
- R4: Opcode 1 (subtract) gives pop 2, push 1 and `push_d0` = (nos - tos) mod 256. Carry is set to 1 exactly when nos < tos (a borrow).
- R5: Opcode 2 (multiply) gives pop 2, push 2, `push_d0` = low byte of nos*tos and `push_d1` = high byte, which ends on top. Carry is unchanged.
- R6: Opcodes 3, 4 and 5 (AND, OR, XOR of nos with tos) give pop 2, push 1 and the bitwise result. Carry is unchanged.
- R7: Opcodes 6, 9 and 10 act on tos only and give pop 1, push 1. Opcode 6 is the bitwise complement, opcode 9 is tos+1 and opcode 10 is tos-1, both increment and decrement wrapping mod 256. Carry is unchanged and nos has no effect.
- R8: Opcode 7 (shift left) gives pop 1, push 1 and tos*2 mod 256, with old bit 7 moved into carry. Opcode 8 (shift right) gives pop 1, push 1 and tos/2, with old bit 0 moved into carry.
- R9: Opcodes 11 to 15 still produce a `done` pulse, but with pop 0 and push 0, and carry is unchanged.
- R10: For every operation that pushes a single byte, `push_d1` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe, one operation per high cycle |
| op_code | input | 4 | Operation select |
| tos | input | DW | Top stack byte (operand B) |
| nos | input | DW | Second stack byte (operand A) |
| done | output | 1 | Result valid, one cycle after the request |
| pop_cnt | output | 2 | Bytes to remove from the stack |
| push_cnt | output | 2 | Bytes to add after the removal |
| push_d0 | output | DW | First byte pushed |
| push_d1 | output | DW | Second byte pushed (new top when push_cnt is 2) |
| carry | output | 1 | Carry flag for branch tests |

## Verification
Every result falls due exactly one clock after the cycle in which its request was accepted. This holds for the counts, both data bytes and the carry flag. The driver records the due cycle with each expected item. The monitor samples on the falling edge that follows the registering edge and rejects any item that arrives in the wrong cycle or arrives when nothing is due. In idle cycles the monitor confirms that both counts are zero. Carry is predicted by a running model in the driver, so an operation that should keep the flag is checked against whatever the preceding operations left in it.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

   typedef enum logic [3:0] {
      OPC_ADD = 4'd0,
      OPC_SUB = 4'd1,
      OPC_MUL = 4'd2,
      OPC_AND = 4'd3,
      OPC_OR  = 4'd4,
      OPC_XOR = 4'd5,
      OPC_NOT = 4'd6,
      OPC_SHL = 4'd7,
      OPC_SHR = 4'd8,
      OPC_INC = 4'd9,
      OPC_DEC = 4'd10
   } opc_e;

   localparam int unsigned OPC_LAST = 10;

   function automatic logic [1:0] pops_of(input logic [3:0] c);
      case (c)
         4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: pops_of = 2'd2;
         4'd6, 4'd7, 4'd8, 4'd9, 4'd10:      pops_of = 2'd1;
         default:                            pops_of = 2'd0;
      endcase
   endfunction

   function automatic logic [1:0] pushes_of(input logic [3:0] c);
      if (c == 4'd2)
         pushes_of = 2'd2;
      else if (c <= 4'(OPC_LAST))
         pushes_of = 2'd1;
      else
         pushes_of = 2'd0;
   endfunction

   function automatic logic is_bitwise(input logic [3:0] c);
      is_bitwise = (c == 4'd3) || (c == 4'd4) || (c == 4'd5) || (c == 4'd6);
   endfunction

endpackage

// File: rtl/stk_alu_bitwise.sv
module stk_alu_bitwise #(
   parameter int unsigned DW = 8
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] res
);
   import stk_alu_pkg::*;

   always_comb begin
      case (op)
         OPC_AND: res = a & b;
         OPC_OR:  res = a | b;
         OPC_XOR: res = a ^ b;
         OPC_NOT: res = ~b;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/stk_alu_arith.sv
module stk_alu_arith #(
   parameter int unsigned DW = 8
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] res,
   output logic          c_new,
   output logic          c_wr
);
   import stk_alu_pkg::*;

   localparam int unsigned EW = DW + 1;

   logic [EW-1:0] sum_ext;
   logic [EW-1:0] dif_ext;

   assign sum_ext = {1'b0, a} + {1'b0, b};
   assign dif_ext = {1'b0, a} - {1'b0, b};

   always_comb begin
      res   = '0;
      c_new = 1'b0;
      c_wr  = 1'b0;
      case (op)
         OPC_ADD: begin
            res   = sum_ext[DW-1:0];
            c_new = sum_ext[DW];
            c_wr  = 1'b1;
         end
         OPC_SUB: begin
            res   = dif_ext[DW-1:0];
            c_new = dif_ext[DW];
            c_wr  = 1'b1;
         end
         OPC_SHL: begin
            res   = {b[DW-2:0], 1'b0};
            c_new = b[DW-1];
            c_wr  = 1'b1;
         end
         OPC_SHR: begin
            res   = {1'b0, b[DW-1:1]};
            c_new = b[0];
            c_wr  = 1'b1;
         end
         OPC_INC: res = b + DW'(1);
         OPC_DEC: res = b - DW'(1);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/stk_alu_mult.sv
module stk_alu_mult #(
   parameter int unsigned DW        = 8,
   parameter int unsigned MUL_STYLE = 1
) (
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [2*DW-1:0] prod
);
   localparam int unsigned PW = 2 * DW;

   generate
      if (MUL_STYLE == 0) begin : g_op
         assign prod = PW'(a) * PW'(b);
      end else begin : g_array
         logic [PW-1:0] pp [DW];
         for (genvar i = 0; i < DW; i++) begin : g_row
            assign pp[i] = b[i] ? (PW'(a) << i) : '0;
         end
         always_comb begin
            prod = '0;
            for (int k = 0; k < DW; k++) begin
               prod = prod + pp[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
   parameter int unsigned DW        = 8,
   parameter int unsigned MUL_STYLE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [3:0]    op_code,
   input  logic [DW-1:0] tos,
   input  logic [DW-1:0] nos,
   output logic          done,
   output logic [1:0]    pop_cnt,
   output logic [1:0]    push_cnt,
   output logic [DW-1:0] push_d0,
   output logic [DW-1:0] push_d1,
   output logic          carry
);
   import stk_alu_pkg::*;

   localparam int unsigned PW = 2 * DW;

   generate
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("stk_alu: DW must lie in 2..32");
      end
      if (MUL_STYLE > 1) begin : g_bad_style
         $error("stk_alu: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DW-1:0] bw_res;
   logic [DW-1:0] ar_res;
   logic          ar_c;
   logic          ar_cwr;
   logic [PW-1:0] mul_prod;

   stk_alu_bitwise #(.DW(DW)) u_bitwise (
      .op  (op_code),
      .a   (nos),
      .b   (tos),
      .res (bw_res)
   );

   stk_alu_arith #(.DW(DW)) u_arith (
      .op    (op_code),
      .a     (nos),
      .b     (tos),
      .res   (ar_res),
      .c_new (ar_c),
      .c_wr  (ar_cwr)
   );

   stk_alu_mult #(.DW(DW), .MUL_STYLE(MUL_STYLE)) u_mult (
      .a    (nos),
      .b    (tos),
      .prod (mul_prod)
   );

   logic [DW-1:0] nxt_d0;
   logic [DW-1:0] nxt_d1;

   always_comb begin
      nxt_d1 = '0;
      if (op_code == OPC_MUL) begin
         nxt_d0 = mul_prod[DW-1:0];
         nxt_d1 = mul_prod[PW-1:DW];
      end else if (is_bitwise(op_code)) begin
         nxt_d0 = bw_res;
      end else begin
         nxt_d0 = ar_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         pop_cnt  <= '0;
         push_cnt <= '0;
         push_d0  <= '0;
         push_d1  <= '0;
         carry    <= 1'b0;
      end else begin
         done <= op_valid;
         if (op_valid) begin
            pop_cnt  <= pops_of(op_code);
            push_cnt <= pushes_of(op_code);
            push_d0  <= nxt_d0;
            push_d1  <= nxt_d1;
            if (ar_cwr) carry <= ar_c;
         end else begin
            pop_cnt  <= '0;
            push_cnt <= '0;
         end
      end
   end

   // R2: result strobe exactly one cycle after the request
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> done);

   // R2: idle cycles carry no stack movement
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!done && pop_cnt == 2'd0 && push_cnt == 2'd0));

   // R5: two-byte product, high byte on top
   p_mul_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OPC_MUL) |=>
      (push_cnt == 2'd2 && {push_d1, push_d0} == (PW'($past(nos)) * PW'($past(tos)))));

   // R6: bitwise operations keep the flag
   p_carry_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OPC_AND || op_code == OPC_OR || op_code == OPC_XOR)) |=>
      $stable(carry));

   // R7: complement, increment and decrement keep the flag
   p_carry_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OPC_NOT || op_code == OPC_INC || op_code == OPC_DEC)) |=>
      $stable(carry));

   // R9: unused codes move nothing and keep the flag
   p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code > 4'(OPC_LAST)) |=>
      (pop_cnt == 2'd0 && push_cnt == 2'd0 && $stable(carry)));

   // R10: single-byte results leave the second byte clear
   p_single_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && push_cnt == 2'd1) |-> (push_d1 == '0));
endmodule

// File: tb/stk_alu_bench.sv
module stk_alu_bench;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [3:0]    op_code = '0;
   logic [DW-1:0] tos = '0;
   logic [DW-1:0] nos = '0;
   logic          done;
   logic [1:0]    pop_cnt;
   logic [1:0]    push_cnt;
   logic [DW-1:0] push_d0;
   logic [DW-1:0] push_d1;
   logic          carry;

   stk_alu #(.DW(DW)) u_stk_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .tos      (tos),
      .nos      (nos),
      .done     (done),
      .pop_cnt  (pop_cnt),
      .push_cnt (push_cnt),
      .push_d0  (push_d0),
      .push_d1  (push_d1),
      .carry    (carry)
   );

   always #5 clk = ~clk;

   typedef struct packed {
      logic [1:0] pop;
      logic [1:0] push;
      logic [7:0] d0;
      logic [7:0] d1;
      logic       c;
      int         due;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   logic  m_carry = 1'b0;
   logic  finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic issue(input logic [3:0] oc, input logic [7:0] a, input logic [7:0] b,
                        input string tag);
      exp_t e;
      logic [15:0] p;
      logic [8:0]  w;
      e.pop = 2'd0; e.push = 2'd0; e.d0 = 8'd0; e.d1 = 8'd0;
      case (oc)
         4'd0: begin w = {1'b0, a} + {1'b0, b}; e.d0 = w[7:0]; m_carry = w[8];
                     e.pop = 2; e.push = 1; end
         4'd1: begin e.d0 = a - b; m_carry = (a < b); e.pop = 2; e.push = 1; end
         4'd2: begin p = 16'(a) * 16'(b); e.d0 = p[7:0]; e.d1 = p[15:8];
                     e.pop = 2; e.push = 2; end
         4'd3: begin e.d0 = a & b; e.pop = 2; e.push = 1; end
         4'd4: begin e.d0 = a | b; e.pop = 2; e.push = 1; end
         4'd5: begin e.d0 = a ^ b; e.pop = 2; e.push = 1; end
         4'd6: begin e.d0 = ~b; e.pop = 1; e.push = 1; end
         4'd7: begin e.d0 = 8'((16'(b) * 2) % 256); m_carry = b[7]; e.pop = 1; e.push = 1; end
         4'd8: begin e.d0 = b / 2; m_carry = b[0]; e.pop = 1; e.push = 1; end
         4'd9: begin e.d0 = b + 8'd1; e.pop = 1; e.push = 1; end
         4'd10: begin e.d0 = b - 8'd1; e.pop = 1; e.push = 1; end
         default: ;
      endcase
      e.c   = m_carry;
      e.due = cyc + 1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      op_code  = oc;
      nos      = a;
      tos      = b;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      op_code  = 4'hF;
      nos      = 8'hEE;
      tos      = 8'hEE;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            checks++;
            if (exp_q.size() == 0) begin
               failures++;
               $display("FAIL R2: done=1 with nothing due at cycle %0d (expected done=0)", cyc);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (cyc != e.due || pop_cnt != e.pop || push_cnt != e.push ||
                   push_d0 != e.d0 || push_d1 != e.d1 || carry != e.c) begin
                  failures++;
                  $display("FAIL %s: cyc=%0d pop=%0d push=%0d d0=%h d1=%h c=%b expected cyc=%0d pop=%0d push=%0d d0=%h d1=%h c=%b",
                           t, cyc, pop_cnt, push_cnt, push_d0, push_d1, carry,
                           e.due, e.pop, e.push, e.d0, e.d1, e.c);
               end
            end
         end else begin
            if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
               checks++;
               failures++;
               $display("FAIL R2: done=0 at cycle %0d, expected done=1 (due %0d)", cyc, exp_q[0].due);
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
            if (pop_cnt != 2'd0 || push_cnt != 2'd0) begin
               checks++;
               failures++;
               $display("FAIL R2: idle counts pop=%0d push=%0d expected 0 0", pop_cnt, push_cnt);
            end
         end
      end
   end

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog: run did not complete (expected completion)");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      checks++;
      if (done !== 1'b0 || pop_cnt !== 2'd0 || push_cnt !== 2'd0 || push_d0 !== 8'd0 ||
          push_d1 !== 8'd0 || carry !== 1'b0) begin
         failures++;
         $display("FAIL R1: done=%b pop=%0d push=%0d d0=%h d1=%h c=%b expected all zero",
                  done, pop_cnt, push_cnt, push_d0, push_d1, carry);
      end
      rst_n = 1'b1;
      idle(2);

      issue(4'd0, 8'd5,   8'd6,   "R3");
      issue(4'd0, 8'd200, 8'd100, "R3");
      issue(4'd3, 8'hF0,  8'h3C,  "R6");
      issue(4'd4, 8'h0F,  8'h30,  "R6");
      idle(2);
      issue(4'd5, 8'hAA,  8'hFF,  "R6");
      issue(4'd1, 8'd10,  8'd3,   "R4");
      issue(4'd1, 8'd3,   8'd10,  "R4");
      issue(4'd1, 8'd7,   8'd7,   "R4");
      issue(4'd2, 8'd5,   8'd6,   "R5");
      issue(4'd0, 8'd255, 8'd1,   "R3");
      issue(4'd2, 8'd255, 8'd255, "R5");
      issue(4'd2, 8'd16,  8'd32,  "R5");
      idle(1);
      issue(4'd7, 8'h00,  8'h81,  "R8");
      issue(4'd8, 8'h00,  8'h02,  "R8");
      issue(4'd8, 8'h00,  8'h01,  "R8");
      issue(4'd6, 8'h77,  8'h5A,  "R7");
      issue(4'd9, 8'h12,  8'hFF,  "R7");
      issue(4'd10, 8'h34, 8'h00,  "R7");
      issue(4'd7, 8'h00,  8'h40,  "R8");
      issue(4'd9, 8'hFF,  8'h41,  "R10");
      issue(4'd11, 8'd1,  8'd2,   "R9");
      issue(4'd15, 8'd9,  8'd9,   "R9");
      idle(3);

      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R2: %0d results never arrived (expected 0)", exp_q.size());
      end
      finished = 1'b1;
      summary();
   end
endmodule